// File: doc/BRIEF.md
# Pad Function Multiplexer with Auxiliary-Core Routing

This block sits between 126 chip pads and the logic that wants to use them. The pads are grouped into six banks: A has 16 pads, B has 28, C has 24, D has 24, E has 24 and F has 10. Every pad has its own 3-bit function code, held in a configuration register. The code decides where the pad's output data, output enable and input go. The choices are the plain GPIO controller, one of three peripheral functions, or one of four small auxiliary cores. Each auxiliary core exposes a 28-line GPIO port.

Routing to an auxiliary core renumbers the pad onto a core GPIO index:

- Banks B to E keep their pin number.
- Bank A occupies indices 0 to 15.
- Bank F continues from index 16.

Because of this, pads from several banks can fold onto the same core index. A core's output for that index fans out to every pad that selects the core there. On the input side a fixed priority picks a single pad.

Software programs the codes through a 32-bit register port. Each word holds ten codes, and the stored values can be read back. The pad cells, the peripherals and the cores lie outside the block.

Top module: `pinmux_top`

## Requirements
- R1: After a synchronous reset every function code is 0, `cfg_rdata` is 0, and every pad follows the GPIO controller.
- R2: Pads are numbered globally as follows: A0..A15 are 0..15, B0..B27 are 16..43, C0..C23 are 44..67, D0..D23 are 68..91, E0..E23 are 92..115, and F0..F9 are 116..125. Configuration word w holds the codes of pads 10w to 10w+9. Pad 10w+k sits in bits [3k+2:3k], and bits 31:30 read as 0.
- R3: A write with `cfg_we` high stores the addressed word at that clock edge. `cfg_rdata` presents the stored word at `cfg_addr`, registered, one clock after the address is applied. Addresses 13 to 15 read 0, and writes to them change nothing.
- R4: Code 0 connects `pad_out`/`pad_oe` of pad p to `gpio_out[p]`/`gpio_oe[p]` and passes `pad_in[p]` to `gpio_in[p]`. For any other code, `gpio_in[p]` is 0.
- R5: Code 1, 2 or 3 selects peripheral function f = code-1. The pad's output and enable come from bit f*126+p of `fn_out`/`fn_oe`, and `fn_in` bit f*126+p carries `pad_in[p]`. For every other f that bit of `fn_in` is 0.
- R6: Code 4, 5, 6 or 7 selects auxiliary core c = code-4. The pad's output and enable come from bit c*28+i of `core_out`/`core_oe`, where i is the pad's core index.
- R7: The core index of a pad in bank B, C, D or E is its pin number within the bank. For bank A it is the pin number. For bank F it is 16 plus the pin number.
- R8: When several pads select the same core at the same core index, `core_in` for that index takes the input of the pad with the lowest global number, which is the lowest bank letter.
- R9: A `core_in` bit that no pad selects reads 0.
- R10: The output and enable of one core index reach every pad that selects that core and maps to that index.
- R11: Word 12 holds pads 120..125 in bits 17:0. Bits 31:18 of that word read 0 and ignore written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered read data of the addressed word |
| pad_in | input | 126 | Input level seen at each pad |
| pad_out | output | 126 | Output data driven towards each pad |
| pad_oe | output | 126 | Output enable towards each pad |
| gpio_out | input | 126 | GPIO controller output data, one bit per pad |
| gpio_oe | input | 126 | GPIO controller output enable, one bit per pad |
| gpio_in | output | 126 | Pad input returned to the GPIO controller |
| fn_out | input | 378 | Peripheral output data, bit f*126+p |
| fn_oe | input | 378 | Peripheral output enable, bit f*126+p |
| fn_in | output | 378 | Pad input returned to peripheral f, bit f*126+p |
| core_out | input | 112 | Auxiliary core output data, bit c*28+i |
| core_oe | input | 112 | Auxiliary core output enable, bit c*28+i |
| core_in | output | 112 | Input delivered to auxiliary core c index i |

## Verification
The bench first sweeps every code uniformly across all pads and then applies a mixed per-pad pattern. In each case it compares all routed vectors against a bank arithmetic model.

- A design that folds bank F onto indices 0..9, or that shifts a bank's base, drives those pads from the wrong core line.
- A reversed priority chain lets bank B or a later bank override bank A on `core_in`.
- A missing default makes unselected core indices float to a pad's level instead of reading 0.

The partial last word and the unmapped addresses are written with all ones. A design that kept stray bits, or that aliased addresses 13 to 15 onto real words, shows up either in the read-back or in the routing of pads 0..9.

// File: rtl/pinmux_pkg.sv
`timescale 1ns/1ps
package pinmux_pkg;

  // Core GPIO index for a global pad number; banks A..E keep their local
  // number, bank F is appended after bank A's range.
  function automatic int pad_core_idx(int p, int na, int nb, int nc, int nd, int ne);
    int r;
    r = p;
    if (r < na) return r;
    r -= na;
    if (r < nb) return r;
    r -= nb;
    if (r < nc) return r;
    r -= nc;
    if (r < nd) return r;
    r -= nd;
    if (r < ne) return r;
    r -= ne;
    return na + r;
  endfunction

  // Global pad in bank b (0=A..5=F) that maps to core index i, or -1.
  function automatic int core_src_pad(int b, int i, int na, int nb, int nc,
                                      int nd, int ne, int nf);
    int base, size, loc;
    base = 0;
    size = na;
    loc  = i;
    case (b)
      1: begin base = na;                size = nb; end
      2: begin base = na + nb;           size = nc; end
      3: begin base = na + nb + nc;      size = nd; end
      4: begin base = na + nb + nc + nd; size = ne; end
      5: begin base = na + nb + nc + nd + ne; size = nf; loc = i - na; end
      default: ;
    endcase
    if (loc >= 0 && loc < size) return base + loc;
    return -1;
  endfunction

endpackage

// File: rtl/pinmux_cfg_regs.sv
`timescale 1ns/1ps
module pinmux_cfg_regs #(
  parameter int NPAD   = 126,
  parameter int SEL_W  = 3,
  parameter int DATA_W = 32,
  parameter int NWORD  = 13,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [DATA_W-1:0]       cfg_wdata,
  output logic [DATA_W-1:0]       cfg_rdata,
  output logic [NPAD*SEL_W-1:0]   sel_flat
);
  localparam int PER_WORD = DATA_W / SEL_W;

  logic [DATA_W-1:0] words [NWORD];
  logic [DATA_W-1:0] unused_wbits;
  assign unused_wbits = cfg_wdata;

  for (genvar p = 0; p < NPAD; p++) begin : g_pad
    localparam int W = p / PER_WORD;
    localparam int K = p % PER_WORD;
    logic [SEL_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (cfg_we && cfg_addr == ADDR_W'(W))
        q <= cfg_wdata[K*SEL_W +: SEL_W];
    end
    assign sel_flat[p*SEL_W +: SEL_W] = q;
  end

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    localparam int FIRST = w * PER_WORD;
    localparam int USED  = (NPAD - FIRST < PER_WORD) ? (NPAD - FIRST) : PER_WORD;
    logic [DATA_W-1:0] v;
    assign v[DATA_W-1:USED*SEL_W] = '0;
    assign v[USED*SEL_W-1:0] = sel_flat[FIRST*SEL_W +: USED*SEL_W];
    assign words[w] = v;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cfg_rdata <= '0;
    else if (cfg_addr < ADDR_W'(NWORD))
      cfg_rdata <= words[cfg_addr];
    else
      cfg_rdata <= '0;
  end
endmodule

// File: rtl/pinmux_out_route.sv
`timescale 1ns/1ps
module pinmux_out_route
  import pinmux_pkg::*;
#(
  parameter int BANK_A = 16, BANK_B = 28, BANK_C = 24,
  parameter int BANK_D = 24, BANK_E = 24, BANK_F = 10,
  parameter int NPAD   = 126,
  parameter int N_FN   = 3,
  parameter int N_CORE = 4,
  parameter int CORE_W = 28,
  parameter int SEL_W  = 3
) (
  input  logic [NPAD*SEL_W-1:0]    sel_flat,
  input  logic [NPAD-1:0]          gpio_out,
  input  logic [NPAD-1:0]          gpio_oe,
  input  logic [N_FN*NPAD-1:0]     fn_out,
  input  logic [N_FN*NPAD-1:0]     fn_oe,
  input  logic [N_CORE*CORE_W-1:0] core_out,
  input  logic [N_CORE*CORE_W-1:0] core_oe,
  output logic [NPAD-1:0]          pad_out,
  output logic [NPAD-1:0]          pad_oe
);
  localparam int NOPT = 1 << SEL_W;

  for (genvar p = 0; p < NPAD; p++) begin : g_pad
    localparam int IDX = pad_core_idx(p, BANK_A, BANK_B, BANK_C, BANK_D, BANK_E);
    logic [NOPT-1:0]  opt_o, opt_e;
    logic [SEL_W-1:0] sel;
    assign sel = sel_flat[p*SEL_W +: SEL_W];

    for (genvar s = 0; s < NOPT; s++) begin : g_opt
      if (s == 0) begin : g_gpio
        assign opt_o[s] = gpio_out[p];
        assign opt_e[s] = gpio_oe[p];
      end else if (s <= N_FN) begin : g_fn
        assign opt_o[s] = fn_out[(s-1)*NPAD + p];
        assign opt_e[s] = fn_oe[(s-1)*NPAD + p];
      end else if (s - 1 - N_FN < N_CORE && IDX < CORE_W) begin : g_core
        assign opt_o[s] = core_out[(s-1-N_FN)*CORE_W + IDX];
        assign opt_e[s] = core_oe[(s-1-N_FN)*CORE_W + IDX];
      end else begin : g_none
        assign opt_o[s] = 1'b0;
        assign opt_e[s] = 1'b0;
      end
    end

    assign pad_out[p] = opt_o[sel];
    assign pad_oe[p]  = opt_e[sel];
  end
endmodule

// File: rtl/pinmux_in_route.sv
`timescale 1ns/1ps
module pinmux_in_route
  import pinmux_pkg::*;
#(
  parameter int BANK_A = 16, BANK_B = 28, BANK_C = 24,
  parameter int BANK_D = 24, BANK_E = 24, BANK_F = 10,
  parameter int NPAD   = 126,
  parameter int N_FN   = 3,
  parameter int N_CORE = 4,
  parameter int CORE_W = 28,
  parameter int SEL_W  = 3
) (
  input  logic [NPAD*SEL_W-1:0]    sel_flat,
  input  logic [NPAD-1:0]          pad_in,
  output logic [NPAD-1:0]          gpio_in,
  output logic [N_FN*NPAD-1:0]     fn_in,
  output logic [N_CORE*CORE_W-1:0] core_in
);
  localparam int NBANK = 6;

  for (genvar p = 0; p < NPAD; p++) begin : g_pad
    logic [SEL_W-1:0] sel;
    assign sel = sel_flat[p*SEL_W +: SEL_W];
    assign gpio_in[p] = (sel == '0) & pad_in[p];
    for (genvar f = 0; f < N_FN; f++) begin : g_fn
      assign fn_in[f*NPAD + p] = (sel == SEL_W'(f + 1)) & pad_in[p];
    end
  end

  // One short priority chain per core line: at most one candidate pad per bank.
  for (genvar c = 0; c < N_CORE; c++) begin : g_core
    for (genvar i = 0; i < CORE_W; i++) begin : g_idx
      logic [NBANK-1:0] hit, dat;
      logic v;
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int P = core_src_pad(b, i, BANK_A, BANK_B, BANK_C,
                                        BANK_D, BANK_E, BANK_F);
        if (P >= 0) begin : g_src
          assign hit[b] = sel_flat[P*SEL_W +: SEL_W] == SEL_W'(1 + N_FN + c);
          assign dat[b] = pad_in[P];
        end else begin : g_nosrc
          assign hit[b] = 1'b0;
          assign dat[b] = 1'b0;
        end
      end
      always_comb begin
        v = 1'b0;
        for (int b = NBANK - 1; b >= 0; b--)
          if (hit[b]) v = dat[b];
      end
      assign core_in[c*CORE_W + i] = v;
    end
  end
endmodule

// File: rtl/pinmux_top.sv
`timescale 1ns/1ps
module pinmux_top #(
  parameter int BANK_A = 16,
  parameter int BANK_B = 28,
  parameter int BANK_C = 24,
  parameter int BANK_D = 24,
  parameter int BANK_E = 24,
  parameter int BANK_F = 10,
  parameter int N_FN   = 3,
  parameter int N_CORE = 4,
  parameter int CORE_W = 28,
  parameter int SEL_W  = 3,
  parameter int DATA_W = 32,
  localparam int NPAD     = BANK_A + BANK_B + BANK_C + BANK_D + BANK_E + BANK_F,
  localparam int PER_WORD = DATA_W / SEL_W,
  localparam int NWORD    = (NPAD + PER_WORD - 1) / PER_WORD,
  localparam int ADDR_W   = $clog2(NWORD)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [DATA_W-1:0]        cfg_wdata,
  output logic [DATA_W-1:0]        cfg_rdata,
  input  logic [NPAD-1:0]          pad_in,
  output logic [NPAD-1:0]          pad_out,
  output logic [NPAD-1:0]          pad_oe,
  input  logic [NPAD-1:0]          gpio_out,
  input  logic [NPAD-1:0]          gpio_oe,
  output logic [NPAD-1:0]          gpio_in,
  input  logic [N_FN*NPAD-1:0]     fn_out,
  input  logic [N_FN*NPAD-1:0]     fn_oe,
  output logic [N_FN*NPAD-1:0]     fn_in,
  input  logic [N_CORE*CORE_W-1:0] core_out,
  input  logic [N_CORE*CORE_W-1:0] core_oe,
  output logic [N_CORE*CORE_W-1:0] core_in
);
  logic [NPAD*SEL_W-1:0] sel_flat;

  pinmux_cfg_regs #(
    .NPAD(NPAD), .SEL_W(SEL_W), .DATA_W(DATA_W), .NWORD(NWORD), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sel_flat(sel_flat)
  );

  pinmux_out_route #(
    .BANK_A(BANK_A), .BANK_B(BANK_B), .BANK_C(BANK_C), .BANK_D(BANK_D),
    .BANK_E(BANK_E), .BANK_F(BANK_F), .NPAD(NPAD), .N_FN(N_FN),
    .N_CORE(N_CORE), .CORE_W(CORE_W), .SEL_W(SEL_W)
  ) u_out (
    .sel_flat(sel_flat), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
    .fn_out(fn_out), .fn_oe(fn_oe), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  pinmux_in_route #(
    .BANK_A(BANK_A), .BANK_B(BANK_B), .BANK_C(BANK_C), .BANK_D(BANK_D),
    .BANK_E(BANK_E), .BANK_F(BANK_F), .NPAD(NPAD), .N_FN(N_FN),
    .N_CORE(N_CORE), .CORE_W(CORE_W), .SEL_W(SEL_W)
  ) u_in (
    .sel_flat(sel_flat), .pad_in(pad_in), .gpio_in(gpio_in),
    .fn_in(fn_in), .core_in(core_in)
  );
endmodule

// File: rtl/pinmux_chk.sv
`timescale 1ns/1ps
module pinmux_chk #(
  parameter int NPAD   = 126,
  parameter int SEL_W  = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cfg_we,
  input logic [ADDR_W-1:0]     cfg_addr,
  input logic [DATA_W-1:0]     cfg_wdata,
  input logic [DATA_W-1:0]     cfg_rdata,
  input logic [NPAD*SEL_W-1:0] sel_flat,
  input logic [NPAD-1:0]       pad_in,
  input logic [NPAD-1:0]       pad_out,
  input logic [NPAD-1:0]       pad_oe,
  input logic [NPAD-1:0]       gpio_out,
  input logic [NPAD-1:0]       gpio_oe,
  input logic [NPAD-1:0]       gpio_in
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sel_flat == '0 && cfg_rdata == '0));

  // R3
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == '0) |=> sel_flat[SEL_W-1:0] == $past(cfg_wdata[SEL_W-1:0]));

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr == '0) |=> cfg_rdata[SEL_W-1:0] == $past(sel_flat[SEL_W-1:0]));

  for (genvar p = 0; p < NPAD; p++) begin : g_pad
    // R4
    gpio_drive_chk: assert property (@(posedge clk) disable iff (rst)
      (sel_flat[p*SEL_W +: SEL_W] == '0) |->
        (pad_out[p] == gpio_out[p] && pad_oe[p] == gpio_oe[p]));
    // R4
    gpio_block_chk: assert property (@(posedge clk) disable iff (rst)
      (sel_flat[p*SEL_W +: SEL_W] != '0) |-> !gpio_in[p]);
    // R4
    gpio_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (sel_flat[p*SEL_W +: SEL_W] == '0) |-> gpio_in[p] == pad_in[p]);
  end
endmodule

bind pinmux_top pinmux_chk #(
  .NPAD(NPAD), .SEL_W(SEL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sel_flat(sel_flat),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
  .gpio_out(gpio_out), .gpio_oe(gpio_oe), .gpio_in(gpio_in)
);

// File: tb/pinmux_top_test.sv
`timescale 1ns/1ps
module pinmux_top_test;
  localparam int NP = 126;
  localparam int NF = 3;
  localparam int NC = 4;
  localparam int CW = 28;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe, gpio_out = '0, gpio_oe = '0, gpio_in;
  logic [NF*NP-1:0] fn_out = '0, fn_oe = '0, fn_in;
  logic [NC*CW-1:0] core_out = '0, core_oe = '0, core_in;

  always #2.5 clk = ~clk;

  pinmux_top uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
    .gpio_in(gpio_in), .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in),
    .core_out(core_out), .core_oe(core_oe), .core_in(core_in)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int msel [NP];

  task automatic chk(string tag, logic [NF*NP-1:0] act, logic [NF*NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bank arithmetic: A 0..15, B 16..43, C 44..67, D 68..91, E 92..115, F 116..125
  function automatic int tb_idx(int p);
    if (p < 16) return p;
    if (p < 44) return p - 16;
    if (p < 68) return p - 44;
    if (p < 92) return p - 68;
    if (p < 116) return p - 92;
    return p - 116 + 16;
  endfunction

  function automatic logic [31:0] pack_word(int w);
    logic [31:0] r = '0;
    for (int k = 0; k < 10; k++)
      if (w < 13 && w*10 + k < NP) r[3*k +: 3] = 3'(msel[w*10 + k]);
    return r;
  endfunction

  task automatic write_word(int a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 13)
      for (int k = 0; k < 10; k++)
        if (a*10 + k < NP) msel[a*10 + k] = int'(d[3*k +: 3]);
  endtask

  task automatic read_word(int a, string tag);
    @(negedge clk);
    cfg_addr = 4'(a);
    @(negedge clk);
    #1 chk(tag, {{(NF*NP-32){1'b0}}, cfg_rdata}, {{(NF*NP-32){1'b0}}, pack_word(a)});
  endtask

  task automatic load_all();
    logic [31:0] d;
    for (int w = 0; w < 13; w++) begin
      d = '0;
      for (int k = 0; k < 10; k++)
        if (w*10 + k < NP) d[3*k +: 3] = 3'(msel[w*10 + k]);
      write_word(w, d);
    end
  endtask

  task automatic shake();
    @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      pad_in[i] = 1'($urandom); gpio_out[i] = 1'($urandom); gpio_oe[i] = 1'($urandom);
    end
    for (int i = 0; i < NF*NP; i++) begin
      fn_out[i] = 1'($urandom); fn_oe[i] = 1'($urandom);
    end
    for (int i = 0; i < NC*CW; i++) begin
      core_out[i] = 1'($urandom); core_oe[i] = 1'($urandom);
    end
  endtask

  task automatic check_routes(string tag);
    logic [NP-1:0] eo, ee, eg;
    logic [NF*NP-1:0] ef;
    logic [NC*CW-1:0] ec;
    int s;
    #1;
    eo = '0; ee = '0; eg = '0; ef = '0; ec = '0;
    for (int p = 0; p < NP; p++) begin
      s = msel[p];
      if (s == 0) begin
        eo[p] = gpio_out[p]; ee[p] = gpio_oe[p]; eg[p] = pad_in[p];
      end else if (s <= 3) begin
        eo[p] = fn_out[(s-1)*NP + p]; ee[p] = fn_oe[(s-1)*NP + p];
        ef[(s-1)*NP + p] = pad_in[p];
      end else begin
        eo[p] = core_out[(s-4)*CW + tb_idx(p)]; ee[p] = core_oe[(s-4)*CW + tb_idx(p)];
      end
    end
    for (int p = NP - 1; p >= 0; p--)
      if (msel[p] >= 4) ec[(msel[p]-4)*CW + tb_idx(p)] = pad_in[p];
    chk({tag, " R4 R5 R6 R7 R10 pad_out"}, {{(NF*NP-NP){1'b0}}, pad_out}, {{(NF*NP-NP){1'b0}}, eo});
    chk({tag, " R4 R5 R6 R10 pad_oe"}, {{(NF*NP-NP){1'b0}}, pad_oe}, {{(NF*NP-NP){1'b0}}, ee});
    chk({tag, " R4 gpio_in"}, {{(NF*NP-NP){1'b0}}, gpio_in}, {{(NF*NP-NP){1'b0}}, eg});
    chk({tag, " R5 fn_in"}, fn_in, ef);
    chk({tag, " R6 R8 R9 core_in"}, {{(NF*NP-NC*CW){1'b0}}, core_in}, {{(NF*NP-NC*CW){1'b0}}, ec});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) msel[p] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    #1 chk("R1 rdata after reset", {{(NF*NP-32){1'b0}}, cfg_rdata}, '0);
    for (int w = 0; w < 13; w++) read_word(w, "R1 R2 reset word");
    for (int t = 0; t < 3; t++) begin shake(); check_routes("R1"); end

    // Uniform sweep of every code over all pads
    for (int v = 0; v < 8; v++) begin
      for (int p = 0; p < NP; p++) msel[p] = v;
      load_all();
      for (int w = 0; w < 13; w++) read_word(w, "R2 R3 uniform readback");
      for (int t = 0; t < 4; t++) begin shake(); check_routes("uniform"); end
    end

    // Mixed per-pad codes
    for (int m = 0; m < 3; m++) begin
      for (int p = 0; p < NP; p++) msel[p] = (p*5 + p/7 + m*3) % 8;
      load_all();
      for (int w = 0; w < 13; w++) read_word(w, "R2 mixed readback");
      for (int t = 0; t < 6; t++) begin shake(); check_routes("mixed"); end
    end

    // R8 priority and R9 empty lines: A5,B5,C5,D5,E5 and F3 (index 19), B19 on core 1
    for (int p = 0; p < NP; p++) msel[p] = 0;
    msel[5] = 5; msel[21] = 5; msel[49] = 5; msel[73] = 5; msel[97] = 5;
    msel[119] = 5; msel[35] = 5;
    load_all();
    for (int t = 0; t < 8; t++) begin shake(); check_routes("R8 priority"); end
    msel[5] = 0; write_word(0, pack_word(0));
    for (int t = 0; t < 4; t++) begin shake(); check_routes("R8 B over C"); end

    // R11 partial last word, R3 unmapped addresses
    write_word(12, 32'hFFFF_FFFF);
    read_word(12, "R11 partial word");
    write_word(13, 32'hFFFF_FFFF);
    write_word(14, 32'hFFFF_FFFF);
    write_word(15, 32'hFFFF_FFFF);
    for (int w = 0; w < 16; w++) read_word(w, "R3 unmapped address");
    shake(); check_routes("R3 R11 after stray writes");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule